// File: doc/BRIEF.md
# Fall-Through Handshake FIFO

This block is a first-in first-out buffer with 16 positions of 4 bits each. It has no full or empty flags. Instead each side has a ready/strobe pair. The writer watches `in_rdy` and strobes `shift_in` to enter the word on `din`. The reader watches `out_rdy` and strobes `shift_out` to remove the word shown on `dout`.

Each position holds one word and a valid bit. A word moves forward one position per clock whenever the position ahead of it is empty, so an entered word falls through to the output end with a visible delay. In the same way, a vacancy made at the output end travels back toward the input one position per clock. The output data can be switched to high impedance with `out_en`, and the handshake keeps running while it is off. A synchronous master reset empties every position.

To build a deeper buffer, chain instances using only the handshake pins. The first instance's `out_rdy` drives the second's `shift_in`, the second's `in_rdy` drives the first's `shift_out`, and data passes from `dout` to `din`.

Top module: `fallthru_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, every position is emptied. After that edge `in_rdy` is 1 and `out_rdy` is 0, and no earlier word appears later.
- R2: A word is entered at a rising edge where `shift_in` and `in_rdy` are both 1. A `shift_in` strobe while `in_rdy` is 0 stores nothing.
- R3: In an empty buffer, `out_rdy` rises exactly DEPTH-1 rising edges after the edge that entered a word (15 with defaults), and not one edge earlier.
- R4: While `out_rdy` is 1, `dout` shows the oldest word and holds it until it is removed. A rising edge with `shift_out` and `out_rdy` both 1 removes it. A `shift_out` strobe while `out_rdy` is 0 removes nothing and is not remembered.
- R5: After a removal, `out_rdy` is 0 for one cycle. If the position behind the output held a word, that word is shown with `out_rdy` 1 after the next rising edge.
- R6: When the output position is emptied in a full buffer, `in_rdy` rises exactly DEPTH-1 rising edges after the removing edge.
- R7: The buffer holds up to DEPTH words and returns them in the order entered, none dropped and none repeated.
- R8: With `out_en` 0, every bit of `dout` is high impedance (with the default TRISTATE=1; TRISTATE=0 drives zeros instead). `out_rdy`, `in_rdy` and removals are not affected.
- R9: Two instances chained through their handshake pins behave as one 2×DEPTH-word buffer that keeps order with no lost or repeated word, even when the strobes at both ends are raised regardless of the ready flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous master reset, active high |
| din | input | WIDTH | Word to enter at the input end |
| shift_in | input | 1 | Entry strobe, sampled at the rising edge |
| in_rdy | output | 1 | High when the input position is empty |
| shift_out | input | 1 | Removal strobe, sampled at the rising edge |
| out_rdy | output | 1 | High when the output position holds a word |
| out_en | input | 1 | Output enable for `dout` |
| dout | output | WIDTH | Word at the output end, or high impedance when disabled |

## Verification
A single word entered into an empty buffer measures the fall-through delay edge by edge. This separates a correct one-position-per-clock ripple from a buffer that is too fast or too slow. A full buffer followed by one removal measures the backward ripple of the vacancy and the one-cycle refill gap at the output. Strobes raised against a low ready flag, at both ends, show whether a design drops, duplicates or queues ignored requests. A randomized stream through two chained instances, replayed from a table of words against an ordering model, checks that transfers at the shared handshake are never lost or doubled.

// File: rtl/fallthru_pkg.sv
package fallthru_pkg;

   // What one storage position does at the next rising edge
   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_LEAVE = 2'd2
   } stage_op_e;

   // Loading has priority; a load and a leave never coincide for one position
   function automatic stage_op_e pick_op(input logic take, input logic give);
      if (take)      return ST_LOAD;
      else if (give) return ST_LEAVE;
      else           return ST_HOLD;
   endfunction

endpackage

// File: rtl/ft_stage.sv
module ft_stage
   import fallthru_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  stage_op_e        op,
   input  logic [WIDTH-1:0] src,
   output logic             valid,
   output logic [WIDTH-1:0] data
);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         case (op)
            ST_LOAD: begin
               valid <= 1'b1;
               data  <= src;
            end
            ST_LEAVE: valid <= 1'b0;
            default:  ;
         endcase
      end
   end

   // R7
   load_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (op == ST_LOAD) |-> !valid);

   // R7
   leave_full_chk: assert property (@(posedge clk) disable iff (rst)
      (op == ST_LEAVE) |-> valid);

endmodule

// File: rtl/ft_outdrv.sv
module ft_outdrv #(
   parameter int WIDTH    = 4,
   parameter bit TRISTATE = 1'b1
) (
   input  logic             en,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] q
);

   generate
      if (TRISTATE) begin : g_hiz
         assign q = en ? word : {WIDTH{1'bz}};
      end else begin : g_zero
         assign q = en ? word : '0;
      end
   endgenerate

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
   import fallthru_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int DEPTH    = 16,
   parameter bit TRISTATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             shift_in,
   output logic             in_rdy,
   input  logic             shift_out,
   output logic             out_rdy,
   input  logic             out_en,
   output logic [WIDTH-1:0] dout
);

   localparam int LAST = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fallthru_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fallthru_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] vld;
   logic [WIDTH-1:0] word [DEPTH];
   stage_op_e        op   [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_pos
         logic [WIDTH-1:0] src;
         logic             take;
         logic             give;

         if (i == 0) begin : g_head
            assign take = shift_in & ~vld[0];
            assign src  = din;
         end else begin : g_body
            assign take = vld[i-1] & ~vld[i];
            assign src  = word[i-1];
         end

         if (i == LAST) begin : g_tail
            assign give = shift_out & vld[i];
         end else begin : g_fwd
            assign give = vld[i] & ~vld[i+1];
         end

         assign op[i] = pick_op(take, give);

         ft_stage #(.WIDTH(WIDTH)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .op    (op[i]),
            .src   (src),
            .valid (vld[i]),
            .data  (word[i])
         );
      end
   endgenerate

   assign in_rdy  = ~vld[0];
   assign out_rdy = vld[LAST];

   ft_outdrv #(.WIDTH(WIDTH), .TRISTATE(TRISTATE)) u_outdrv (
      .en   (out_en),
      .word (word[LAST]),
      .q    (dout)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_rdy && !out_rdy));

   // R7
   occupancy_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (int'($countones(vld)) ==
                       int'($past($countones(vld)))
                       + int'($past(shift_in && in_rdy))
                       - int'($past(shift_out && out_rdy))));

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_rdy && !shift_out) |=> (out_rdy && $stable(word[LAST])));

   // R5
   refill_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (out_rdy && shift_out) |=> !out_rdy);

endmodule

// File: tb/fallthru_fifo_bench.sv
module fallthru_fifo_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam int D = 16;

   // Table of words streamed through the chained pair; expected output is the same order
   localparam logic [3:0] PAT [16] = '{4'h3, 4'hC, 4'h0, 4'hF, 4'h5, 4'hA, 4'h9, 4'h6,
                                       4'h1, 4'hE, 4'h7, 4'h8, 4'h2, 4'hD, 4'hB, 4'h4};

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         rst, si, so, oe;
   logic [W-1:0] din;
   logic         in_rdy, out_rdy;
   logic [W-1:0] dout;

   fallthru_fifo #(.WIDTH(W), .DEPTH(D)) u_fallthru_fifo (
      .clk(clk), .rst(rst), .din(din), .shift_in(si), .in_rdy(in_rdy),
      .shift_out(so), .out_rdy(out_rdy), .out_en(oe), .dout(dout));

   // Chained pair
   logic         c_si, c_so, c_in_rdy, c_out_rdy, mid_rdy, back_rdy;
   logic [W-1:0] c_din, c_dout, mid_data;

   fallthru_fifo #(.WIDTH(W), .DEPTH(D)) u_chain_lo (
      .clk(clk), .rst(rst), .din(c_din), .shift_in(c_si), .in_rdy(c_in_rdy),
      .shift_out(back_rdy), .out_rdy(mid_rdy), .out_en(1'b1), .dout(mid_data));

   fallthru_fifo #(.WIDTH(W), .DEPTH(D)) u_chain_hi (
      .clk(clk), .rst(rst), .din(mid_data), .shift_in(mid_rdy), .in_rdy(back_rdy),
      .shift_out(c_so), .out_rdy(c_out_rdy), .out_en(1'b1), .dout(c_dout));

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [3:0] wval(input int i);
      return 4'((i * 7 + 3) & 15);
   endfunction

   task automatic push(input logic [W-1:0] w);
      while (!in_rdy) @(negedge clk);
      din = w; si = 1'b1;
      @(negedge clk);
      si = 1'b0;
   endtask

   task automatic pop_chk(input logic [W-1:0] w, input string req);
      while (!out_rdy) @(negedge clk);
      chk(dout == w, req, int'(dout), int'(w));
      so = 1'b1;
      @(negedge clk);
      so = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      logic [3:0] q [$];
      int pushed = 0;
      rst = 1'b1; si = 1'b0; so = 1'b0; oe = 1'b1; din = '0;
      c_si = 1'b0; c_so = 1'b0; c_din = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(in_rdy == 1'b1, "R1 in_rdy", int'(in_rdy), 1);
      chk(out_rdy == 1'b0, "R1 out_rdy", int'(out_rdy), 0);
      chk(c_in_rdy && !c_out_rdy, "R1 chain flags", int'({c_in_rdy, c_out_rdy}), 2);

      // R3 fall-through latency
      din = 4'hA; si = 1'b1;
      for (int k = 0; k < D; k++) begin
         @(negedge clk);
         if (k == 0) si = 1'b0;
         if (k == D-2) chk(out_rdy == 1'b0, "R3 early", int'(out_rdy), 0);
         if (k == D-1) begin
            chk(out_rdy == 1'b1, "R3 arrival", int'(out_rdy), 1);
            chk(dout == 4'hA, "R4 dout", int'(dout), 10);
         end
      end

      // R8 output enable off, handshake still works
      oe = 1'b0;
      @(negedge clk);
      chk(dout === 4'bzzzz, "R8 hiz", int'(dout), 0);
      chk(out_rdy == 1'b1, "R8 out_rdy kept", int'(out_rdy), 1);
      so = 1'b1;
      @(negedge clk);
      so = 1'b0;
      chk(out_rdy == 1'b0, "R8 pop while disabled", int'(out_rdy), 0);
      oe = 1'b1;

      // R4 shift_out on empty buffer is ignored and not remembered
      so = 1'b1;
      repeat (3) @(negedge clk);
      so = 1'b0;
      din = 4'h6; si = 1'b1;
      @(negedge clk);
      si = 1'b0;
      repeat (D) @(negedge clk);
      chk(out_rdy == 1'b1 && dout == 4'h6, "R4 ignored pop", int'(dout), 6);
      so = 1'b1;
      @(negedge clk);
      so = 1'b0;
      repeat (20) @(negedge clk);
      chk(out_rdy == 1'b0, "R4 no duplicate", int'(out_rdy), 0);

      // R7 fill to capacity
      for (int i = 0; i < D; i++) push(wval(i));
      repeat (20) @(negedge clk);
      chk(in_rdy == 1'b0, "R7 full", int'(in_rdy), 0);
      // R2 entry against low in_rdy is ignored
      din = 4'hF; si = 1'b1;
      repeat (3) @(negedge clk);
      si = 1'b0;
      chk(out_rdy && dout == wval(0), "R7 head word", int'(dout), int'(wval(0)));

      // R5 refill gap and R6 vacancy ripple
      so = 1'b1;
      for (int k = 0; k < D; k++) begin
         @(negedge clk);
         if (k == 0) begin
            so = 1'b0;
            chk(out_rdy == 1'b0, "R5 gap", int'(out_rdy), 0);
         end
         if (k == 1) chk(out_rdy && dout == wval(1), "R5 refill", int'(dout), int'(wval(1)));
         if (k == D-2) chk(in_rdy == 1'b0, "R6 early", int'(in_rdy), 0);
         if (k == D-1) chk(in_rdy == 1'b1, "R6 arrival", int'(in_rdy), 1);
      end
      for (int i = 1; i < D; i++) pop_chk(wval(i), "R7 order");
      repeat (20) @(negedge clk);
      chk(out_rdy == 1'b0, "R2 ignored entry not stored", int'(out_rdy), 0);

      // R1 reset in mid-operation discards contents
      push(4'h1); push(4'h2);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(in_rdy && !out_rdy, "R1 mid reset", int'({in_rdy, out_rdy}), 2);
      repeat (20) @(negedge clk);
      chk(out_rdy == 1'b0, "R1 contents gone", int'(out_rdy), 0);

      // R9 chained pair, table words, random strobes at both ends
      for (int cyc = 0; cyc < 2500; cyc++) begin
         c_si  = (pushed < 300) && (($urandom % 4) != 0);
         c_din = PAT[pushed % 16] ^ 4'(pushed / 16);
         c_so  = (cyc < 400) ? (($urandom % 8) == 0) : (($urandom % 3) != 0);
         if (c_si && c_in_rdy) begin
            q.push_back(c_din);
            pushed++;
         end
         if (c_so && c_out_rdy) begin
            if (q.size() == 0) chk(1'b0, "R9 extra word", int'(c_dout), -1);
            else begin
               logic [3:0] e;
               e = q.pop_front();
               chk(c_dout == e, "R9 order", int'(c_dout), int'(e));
            end
         end
         @(negedge clk);
      end
      c_si = 1'b0; c_so = 1'b0;
      chk(pushed == 300, "R9 all entered", pushed, 300);
      chk(q.size() == 0 && !c_out_rdy, "R9 drained", q.size(), 0);

      summary();
      $finish;
   end

endmodule